// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the architectural state update a 32-bit core makes when it enters an exception handler. Each cycle it looks at a request mask that holds one bit per exception code. It picks the highest-priority known request. It then loads the two save registers: the return address and the saved status. It writes the rewritten machine state word and emits a one-cycle redirect with the handler vector address.

The return address depends on the exception type. It is the word-aligned PC, the word-aligned PC plus 4, or the pending next-instruction address when a control-flow redirect is already in flight. The saved status keeps a fixed subset of the state word and ORs in the cause bits supplied by the requester. The new state word clears every bit outside a fixed mask. Its little-endian bit then takes the value of the interrupt-endian bit. The vector is placed in high memory when the vector-prefix bit of the state word is set.

Top module: `exc_entry`

## Requirements
- R1: Request bit k of `req_i` stands for exception code k. The codes are: 1 reset, 2 machine check, 3 data storage, 4 instruction storage, 5 external, 6 alignment, 7 program, 8 FP unavailable, 9 decrementer, 12 system call, 13 trace. When several known requests are active, exactly one is taken, in this order: 1, 2, 3, 4, 6, 7, 8, 12, 13, 5, 9.
- R2: The vector is code×0x100. When bit 6 of `msr_i` is set it is ORed with 0xFFF00000; otherwise its upper bits are zero.
- R3: For codes 1, 2, 3, 6, 7 and 8, the return address is `pc_i` with bits [1:0] cleared.
- R4: For codes 12 and 13, the return address is the word-aligned PC plus 4.
- R5: For codes 5 and 9, the return address is `next_pc_i` when `pend_i` is 1, and otherwise the word-aligned PC plus 4.
- R6: For code 4, the return address is `next_pc_i` when `pend_i` is 1, and otherwise the word-aligned PC.
- R7: The saved status is (`msr_i` AND 0x0000FF73) OR `cause_i`.
- R8: The new state word is `msr_i` AND 0xFFFB1041, with bit 0 then replaced by bit 16.
- R9: `redirect_o` is high for exactly the cycle after a request is taken, and the registered outputs change in that same cycle. With no request active, `srr0_o`, `srr1_o` and `msr_o` hold their values.
- R10: Codes 0, 10, 11, 14 and 15 are unknown. When only unknown bits are active, `err_o` pulses for one cycle, `redirect_o` stays low and all state is unchanged. When a known bit is also active, the unknown bits are ignored.
- R11: After reset, all registered outputs and both pulses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| req_i | input | 16 | exception request mask, bit index = code |
| pc_i | input | 32 | address of the current instruction |
| msr_i | input | 32 | current machine state word |
| pend_i | input | 1 | a control-flow redirect is pending |
| next_pc_i | input | 32 | pending next-instruction address |
| cause_i | input | 32 | cause bits merged into the saved status |
| srr0_o | output | 32 | saved return address |
| srr1_o | output | 32 | saved status |
| msr_o | output | 32 | rewritten machine state word |
| redirect_o | output | 1 | one-cycle redirect pulse |
| vector_o | output | 32 | handler vector address |
| err_o | output | 1 | one-cycle pulse for an unknown-only request |

## Verification
The hardest situation to reach is a collision of many requests. Here the external and decrementer codes must lose to every synchronous code, while unknown bits ride along without effect. The bench drives every pair of known codes together and compares the taken code against an arithmetic priority model. It also sweeps each code against both pending states and both vector-prefix settings, with PC values whose low bits are nonzero. Finally, it mixes unknown bits with known ones and with nothing else.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NCODE  = 16;
  localparam int NKNOWN = 11;
  localparam int CW     = $clog2(NCODE);

  typedef enum logic [1:0] {
    RET_PC,
    RET_PC4,
    RET_NEXT_OR_PC,
    RET_NEXT_OR_PC4
  } ret_rule_e;

  // service order, highest first
  function automatic int prio_at(input int k);
    case (k)
      0: return 1;   1: return 2;   2: return 3;  3: return 4;
      4: return 6;   5: return 7;   6: return 8;  7: return 12;
      8: return 13;  9: return 5;   default: return 9;
    endcase
  endfunction

  function automatic ret_rule_e rule_of(input logic [CW-1:0] c);
    case (c)
      4'd12, 4'd13: return RET_PC4;
      4'd4:         return RET_NEXT_OR_PC;
      4'd5, 4'd9:   return RET_NEXT_OR_PC4;
      default:      return RET_PC;
    endcase
  endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic [NCODE-1:0] req_i,
  output logic [NCODE-1:0] grant_o,
  output logic [CW-1:0]    code_o,
  output logic             take_o,
  output logic             unknown_o
);
  logic found;

  always_comb begin
    grant_o = '0;
    code_o  = '0;
    found   = 1'b0;
    for (int k = 0; k < NKNOWN; k++) begin
      if (!found && req_i[prio_at(k)]) begin
        grant_o[prio_at(k)] = 1'b1;
        code_o              = CW'(prio_at(k));
        found               = 1'b1;
      end
    end
    take_o    = found;
    unknown_o = !found && (|req_i);
  end

  always_comb begin
    a_onehot_r1: assert ($onehot0(grant_o));
    a_granted_req_r1: assert ((grant_o & ~req_i) == '0);
  end
endmodule

// File: rtl/exc_target.sv
module exc_target
  import exc_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          OFS_SHIFT = 8,
  parameter logic [31:0] SAVE_MASK = 32'h0000_FF73,
  parameter logic [31:0] KEEP_MASK = 32'hFFFB_1041,
  parameter logic [31:0] HIGH_BASE = 32'hFFF0_0000,
  parameter int          LE_BIT    = 0,
  parameter int          ILE_BIT   = 16,
  parameter int          IP_BIT    = 6
) (
  input  logic [CW-1:0]   code_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] msr_i,
  input  logic            pend_i,
  input  logic [XLEN-1:0] next_pc_i,
  input  logic [XLEN-1:0] cause_i,
  output logic [XLEN-1:0] srr0_o,
  output logic [XLEN-1:0] srr1_o,
  output logic [XLEN-1:0] msr_o,
  output logic [XLEN-1:0] vector_o
);
  logic [XLEN-1:0] pc_al, pc_nx;

  assign pc_al = {pc_i[XLEN-1:2], 2'b00};
  assign pc_nx = pc_al + XLEN'(4);

  always_comb begin
    case (rule_of(code_i))
      RET_PC4:         srr0_o = pc_nx;
      RET_NEXT_OR_PC:  srr0_o = pend_i ? next_pc_i : pc_al;
      RET_NEXT_OR_PC4: srr0_o = pend_i ? next_pc_i : pc_nx;
      default:         srr0_o = pc_al;
    endcase
  end

  assign srr1_o = (msr_i & XLEN'(SAVE_MASK)) | cause_i;

  always_comb begin
    msr_o         = msr_i & XLEN'(KEEP_MASK);
    msr_o[LE_BIT] = msr_o[ILE_BIT];
  end

  assign vector_o = (XLEN'(code_i) << OFS_SHIFT)
                  | (msr_i[IP_BIT] ? XLEN'(HIGH_BASE) : '0);
endmodule

// File: rtl/exc_entry.sv
module exc_entry
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCODE-1:0] req_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  msr_i,
  input  logic             pend_i,
  input  logic [XLEN-1:0]  next_pc_i,
  input  logic [XLEN-1:0]  cause_i,
  output logic [XLEN-1:0]  srr0_o,
  output logic [XLEN-1:0]  srr1_o,
  output logic [XLEN-1:0]  msr_o,
  output logic             redirect_o,
  output logic [XLEN-1:0]  vector_o,
  output logic             err_o
);
  logic [NCODE-1:0] grant;
  logic [CW-1:0]    code;
  logic             take, unknown;
  logic [XLEN-1:0]  srr0_n, srr1_n, msr_n, vec_n;

  exc_arbiter u_arb (
    .req_i     (req_i),
    .grant_o   (grant),
    .code_o    (code),
    .take_o    (take),
    .unknown_o (unknown)
  );

  exc_target #(.XLEN(XLEN)) u_tgt (
    .code_i    (code),
    .pc_i      (pc_i),
    .msr_i     (msr_i),
    .pend_i    (pend_i),
    .next_pc_i (next_pc_i),
    .cause_i   (cause_i),
    .srr0_o    (srr0_n),
    .srr1_o    (srr1_n),
    .msr_o     (msr_n),
    .vector_o  (vec_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srr0_o     <= '0;
      srr1_o     <= '0;
      msr_o      <= '0;
      vector_o   <= '0;
      redirect_o <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      redirect_o <= take;
      err_o      <= unknown;
      if (take) begin
        srr0_o   <= srr0_n;
        srr1_o   <= srr1_n;
        msr_o    <= msr_n;
        vector_o <= vec_n;
      end
    end
  end

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take |=> ($stable(srr0_o) && $stable(srr1_o) && $stable(msr_o) && !redirect_o));
  p_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(redirect_o && err_o));
  p_vec_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> vector_o[7:0] == 8'h00);
  p_le_copy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> msr_o[0] == msr_o[16]);
  p_srr1_bits_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> (srr1_o & ~($past(cause_i) | 32'h0000_FF73)) == '0);
endmodule

// File: tb/tb_exc_entry.sv
module tb_exc_entry;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] req_i = '0;
  logic [31:0] pc_i = '0, msr_i = '0, next_pc_i = '0, cause_i = '0;
  logic        pend_i = 1'b0;
  logic [31:0] srr0_o, srr1_o, msr_o, vector_o;
  logic        redirect_o, err_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  exc_entry dut (.*);

  function automatic int prio(input int k);
    int t[11] = '{1, 2, 3, 4, 6, 7, 8, 12, 13, 5, 9};
    return t[k];
  endfunction

  function automatic int rank(input int c);
    for (int k = 0; k < 11; k++) if (prio(k) == c) return k;
    return 99;
  endfunction

  function automatic logic [31:0] e_srr0(input int c, input logic [31:0] pc,
                                         input logic pd, input logic [31:0] na);
    logic [31:0] a;
    a = pc & 32'hFFFF_FFFC;
    case (c)
      12, 13: return a + 4;
      5, 9:   return pd ? na : a + 4;
      4:      return pd ? na : a;
      default: return a;
    endcase
  endfunction

  function automatic logic [31:0] e_msr(input logic [31:0] m);
    logic [31:0] n;
    n = m & 32'hFFFB_1041;
    n[0] = n[16];
    return n;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // one request cycle; check on the following negedge
  task automatic fire(input logic [15:0] rq, input logic [31:0] pc, input logic [31:0] m,
                      input logic pd, input logic [31:0] na, input logic [31:0] cs);
    @(negedge clk_i);
    req_i = rq; pc_i = pc; msr_i = m; pend_i = pd; next_pc_i = na; cause_i = cs;
    @(negedge clk_i);
    req_i = '0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int codes[11] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 12, 13};
    int unk[5] = '{0, 10, 11, 14, 15};
    logic [31:0] pc, m, na, cs, s0, s1, sm;
    repeat (3) @(negedge clk_i);
    chk("R11 srr0", srr0_o, 0);
    chk("R11 srr1", srr1_o, 0);
    chk("R11 msr", msr_o, 0);
    chk("R11 pulses", {30'd0, redirect_o, err_o}, 0);
    rst_ni = 1'b1;

    // R2..R8 sweep: every code x pending x prefix
    for (int i = 0; i < 11; i++) begin
      for (int v = 0; v < 4; v++) begin
        int c;
        c  = codes[i];
        pc = 32'h1000_0003 + i * 32'h0011_0105 + v;
        m  = 32'hA5A5_5A5A ^ (i * 32'h0101_0101);
        m[6]  = v[1];
        m[16] = v[0] ^ v[1];
        m[0]  = ~m[16];
        na = 32'h0040_0000 + i * 32'h10 + v * 32'h4;
        cs = 32'h0800_0000 >> i;
        fire(16'(1) << c, pc, m, v[0], na, cs);
        chk("R9 redirect", {31'd0, redirect_o}, 1);
        chk("R2 vector", vector_o, (32'(c) << 8) | (m[6] ? 32'hFFF0_0000 : 0));
        if (c == 5 || c == 9) chk("R5 srr0", srr0_o, e_srr0(c, pc, v[0], na));
        else if (c == 4) chk("R6 srr0", srr0_o, e_srr0(c, pc, v[0], na));
        else if (c >= 12) chk("R4 srr0", srr0_o, e_srr0(c, pc, v[0], na));
        else chk("R3 srr0", srr0_o, e_srr0(c, pc, v[0], na));
        chk("R7 srr1", srr1_o, (m & 32'h0000_FF73) | cs);
        chk("R8 msr", msr_o, e_msr(m));
        @(negedge clk_i);
        chk("R9 pulse end", {31'd0, redirect_o}, 0);
      end
    end

    // R1: every pair of known codes
    for (int i = 0; i < 11; i++) begin
      for (int j = i + 1; j < 11; j++) begin
        int w;
        w = (rank(codes[i]) < rank(codes[j])) ? codes[i] : codes[j];
        fire((16'(1) << codes[i]) | (16'(1) << codes[j]), 32'h2000_0000, 32'h0, 1'b0, 32'h0, 32'h0);
        chk("R1 winner", vector_o, 32'(w) << 8);
      end
    end
    fire(16'h33FE, 32'h2000_0000, 32'h0, 1'b0, 32'h0, 32'h0);
    chk("R1 all known", vector_o, 32'h100);
    fire(16'h0220, 32'h2000_0000, 32'h0, 1'b0, 32'h0, 32'h0);
    chk("R1 ext over dec", vector_o, 32'h500);

    // R10: unknown only, then mixed
    fire(16'h0080, 32'h3000_0008, 32'h0000_0040, 1'b0, 32'h0, 32'h5);
    s0 = srr0_o; s1 = srr1_o; sm = msr_o;
    for (int u = 0; u < 5; u++) begin
      fire(16'(1) << unk[u], 32'h4444_4444, 32'hFFFF_FFFF, 1'b1, 32'h1234_5678, 32'hFFFF_0000);
      chk("R10 err", {30'd0, err_o, redirect_o}, 2);
      chk("R10 srr0 kept", srr0_o, s0);
      chk("R10 srr1 kept", srr1_o, s1);
      chk("R10 msr kept", msr_o, sm);
    end
    fire(16'hCC01 | 16'h0200, 32'h5000_0001, 32'h0, 1'b0, 32'h0, 32'h0);
    chk("R10 mixed take", {30'd0, err_o, redirect_o}, 1);
    chk("R10 mixed vector", vector_o, 32'h900);

    // R9: idle cycles hold state while inputs move
    s0 = srr0_o; s1 = srr1_o; sm = msr_o;
    pc_i = 32'hDEAD_BEEF; msr_i = 32'hFFFF_FFFF; cause_i = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk_i);
    chk("R9 idle srr0", srr0_o, s0);
    chk("R9 idle srr1", srr1_o, s1);
    chk("R9 idle msr", msr_o, sm);
    chk("R9 idle pulses", {30'd0, err_o, redirect_o}, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule